// File: doc/BRIEF.md
# SPI NOR Flash Command Sequencer

This block drives a serial NOR flash over a single-bit SPI link. A host hands it one request at a time: an opcode, a 24-bit flash address, a byte count and, for page program, a stream of write bytes that the block pulls one at a time. The block frames the whole command under one chip-select assertion and shifts every field out MSB first in SPI mode 0. Read bytes are returned on a one-cycle strobe.

Only five opcodes are accepted: write enable, 4 KB sector erase, page program, read data and read of the first status register. After an erase or a program, the block polls the status register on its own until the flash stops reporting busy. It then raises a level interrupt that stays set until the next accepted request. The serial clock is the system clock divided by a parameter. Read data is sampled on the rising edges that follow the last transmitted bit, so the flash's first output bit, which it drives on the falling edge just after that bit, is captured one half period later.

Top module: `flash_cmd_seq`

## Requirements
- R1: While rst_ni is low and after it is released, cs_n_o is 1, sck_o is 0, irq_o is 0 and req_ready_o is 1.
- R2: A request is accepted only at a clock edge where req_valid_i and req_ready_o are both 1 and req_op_i is one of 8'h06, 8'h20, 8'h02, 8'h03 or 8'h05. Any other opcode is ignored: cs_n_o stays 1 and req_ready_o stays 1.
- R3: If the accept edge is t0 and the half period is H = SCK_HALF, then cs_n_o falls at t0. sck_o idles low, rises for bit k at edge t0+(2k+1)H, and falls at t0+(2k+2)H.
- R4: mosi_o carries each bit from t0 or from the preceding falling edge, MSB first, in this order: the opcode, then req_addr_i[23:0] for 8'h20, 8'h02 and 8'h03, then, for 8'h02 only, req_len_i bytes taken from wdata_i. wdata_take_o pulses for one cycle at the edge where each write byte is loaded, and wdata_i must hold that byte at that edge.
- R5: For 8'h03, req_len_i bytes are read; for 8'h05, one byte is read. miso_i is sampled on the rising edges after the last transmitted bit. rx_valid_o pulses for one cycle, with the byte on rx_data_o, at the rising edge of the byte's last bit.
- R6: cs_n_o rises at the edge of the frame's final falling sck edge. It stays high for at least 2*SCK_HALF cycles before any next frame.
- R7: req_ready_o is 0 from the accept edge until the block returns to idle. Requests presented meanwhile are ignored.
- R8: After 8'h20 or 8'h02, the block issues 8'h05 frames one after another. It stops when status bit 0 (the last bit received) is 0. Status bytes read by these poll frames never appear on rx_valid_o.
- R9: irq_o goes to 1 at the edge where the last poll frame's gap ends, which is the same edge at which req_ready_o returns to 1. It stays 1 until cleared at the next accept edge.
- R10: 8'h06 sends only its 8 opcode bits in a single frame, with no polling and no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, can accept |
| req_op_i | input | 8 | Flash opcode |
| req_addr_i | input | 24 | Flash byte address |
| req_len_i | input | LEN_W | Data byte count for program/read |
| wdata_i | input | 8 | Current program byte |
| wdata_take_o | output | 1 | Program byte consumed |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | rx_data_o valid strobe |
| irq_o | output | 1 | Erase/program completion flag |
| cs_n_o | output | 1 | Flash chip select, active low |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to flash |
| miso_i | input | 1 | Serial data from flash |

## Verification
The bench builds the block with SCK_HALF=2 and MAX_LEN=256. With this divider, rising and falling strobes, chip-select gaps and sampling points each land on separate system cycles, so an off-by-one in any of them shows up in the per-cycle comparison. The full 256-byte page bound still fits in a few thousand cycles, which lets the bench run the longest program frame. The bench also models a flash that stays busy for a chosen number of polls. This brings multi-poll loops, the suppression of poll status bytes and the timing of the interrupt into reach.

// File: rtl/fsq_pkg.sv
package fsq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_GAP} fsq_state_e;

  localparam logic [7:0] OP_WR_EN  = 8'h06;
  localparam logic [7:0] OP_ERASE  = 8'h20;
  localparam logic [7:0] OP_PROG   = 8'h02;
  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_STATUS = 8'h05;

  function automatic logic op_known(input logic [7:0] op);
    return (op == OP_WR_EN) || (op == OP_ERASE) || (op == OP_PROG) ||
           (op == OP_READ) || (op == OP_STATUS);
  endfunction

  function automatic logic op_has_addr(input logic [7:0] op);
    return (op == OP_ERASE) || (op == OP_PROG) || (op == OP_READ);
  endfunction

  function automatic logic op_needs_poll(input logic [7:0] op);
    return (op == OP_ERASE) || (op == OP_PROG);
  endfunction
endpackage

// File: rtl/fsq_sck_gen.sv
module fsq_sck_gen #(
  parameter int unsigned SCK_HALF = 4,
  localparam int unsigned CW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic sck_o,
  output logic rise_o,
  output logic fall_o
);
  logic [CW-1:0] cnt_q;
  logic          sck_q;
  logic          tick;

  assign tick   = en_i && (cnt_q == CW'(SCK_HALF - 1));
  assign rise_o = tick && !sck_q;
  assign fall_o = tick && sck_q;
  assign sck_o  = sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/fsq_shifter.sv
module fsq_shifter (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] load_byte_i,
  input  logic       shift_i,
  input  logic       sample_i,
  input  logic       miso_i,
  output logic       mosi_o,
  output logic [7:0] rx_next_o
);
  logic [7:0] tx_q;
  logic [7:0] rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (load_i)       tx_q <= load_byte_i;
      else if (shift_i) tx_q <= {tx_q[6:0], 1'b0};
      if (sample_i)     rx_q <= {rx_q[6:0], miso_i};
    end
  end

  assign mosi_o    = tx_q[7];
  assign rx_next_o = {rx_q[6:0], miso_i};
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fsq_pkg::*;
#(
  parameter int unsigned SCK_HALF = 4,
  parameter int unsigned MAX_LEN  = 256,
  localparam int unsigned LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [7:0]       req_op_i,
  input  logic [23:0]      req_addr_i,
  input  logic [LEN_W-1:0] req_len_i,
  input  logic [7:0]       wdata_i,
  output logic             wdata_take_o,
  output logic [7:0]       rx_data_o,
  output logic             rx_valid_o,
  output logic             irq_o,
  output logic             cs_n_o,
  output logic             sck_o,
  output logic             mosi_o,
  input  logic             miso_i
);
  localparam int unsigned IDX_W = $clog2(MAX_LEN + 5);
  localparam int unsigned GAP_W = $clog2(2 * SCK_HALF + 1);

  fsq_state_e       state_q;
  logic             cs_n_q, irq_q, rxv_q, take_q, busy_q;
  logic             poll_frame_q, poll_next_q;
  logic [7:0]       rxd_q;
  logic [23:0]      addr_q;
  logic [IDX_W-1:0] ntx_q, nall_q, byte_q;
  logic [2:0]       bit_q;
  logic [GAP_W-1:0] gap_q;

  logic             sck_rise, sck_fall;
  logic             accept, gap_done, poll_go, poll_start, frame_start;
  logic             frame_last, rx_phase, byte_end;
  logic [IDX_W-1:0] ntx_d, nall_d, nxt_idx;
  logic [7:0]       nxt_byte, load_byte, rx_next;
  logic             nxt_take, sh_load, sh_shift, sh_sample;

  assign req_ready_o  = (state_q == ST_IDLE);
  assign accept       = req_ready_o && req_valid_i && op_known(req_op_i);
  assign gap_done     = (state_q == ST_GAP) && (gap_q == GAP_W'(2 * SCK_HALF - 1));
  assign poll_go      = poll_next_q || (poll_frame_q && busy_q);
  assign poll_start   = gap_done && poll_go;
  assign frame_start  = accept || poll_start;
  assign byte_end     = (bit_q == 3'd7);
  assign frame_last   = (byte_q == nall_q - IDX_W'(1)) && byte_end;
  assign rx_phase     = (byte_q >= ntx_q);
  assign nxt_idx      = byte_q + IDX_W'(1);

  // frame sizes in bytes: transmitted part and whole frame
  always_comb begin
    ntx_d = IDX_W'(1);
    if (op_has_addr(req_op_i)) ntx_d = ntx_d + IDX_W'(3);
    if (req_op_i == OP_PROG)   ntx_d = ntx_d + IDX_W'(req_len_i);
    nall_d = ntx_d;
    if (req_op_i == OP_READ)        nall_d = nall_d + IDX_W'(req_len_i);
    else if (req_op_i == OP_STATUS) nall_d = nall_d + IDX_W'(1);
  end

  // source of the next transmitted byte
  always_comb begin
    nxt_byte = '0;
    nxt_take = 1'b0;
    if (nxt_idx < ntx_q) begin
      if (nxt_idx == IDX_W'(1))      nxt_byte = addr_q[23:16];
      else if (nxt_idx == IDX_W'(2)) nxt_byte = addr_q[15:8];
      else if (nxt_idx == IDX_W'(3)) nxt_byte = addr_q[7:0];
      else begin
        nxt_byte = wdata_i;
        nxt_take = 1'b1;
      end
    end
  end

  assign load_byte = accept ? req_op_i : (poll_start ? OP_STATUS : nxt_byte);
  assign sh_load   = frame_start || (sck_fall && !frame_last && byte_end);
  assign sh_shift  = sck_fall && !frame_last && !byte_end;
  assign sh_sample = sck_rise && rx_phase;

  fsq_sck_gen #(.SCK_HALF(SCK_HALF)) u_sck (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (state_q == ST_SHIFT),
    .sck_o  (sck_o),
    .rise_o (sck_rise),
    .fall_o (sck_fall)
  );

  fsq_shifter u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (sh_load),
    .load_byte_i (load_byte),
    .shift_i     (sh_shift),
    .sample_i    (sh_sample),
    .miso_i      (miso_i),
    .mosi_o      (mosi_o),
    .rx_next_o   (rx_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      cs_n_q       <= 1'b1;
      irq_q        <= 1'b0;
      rxv_q        <= 1'b0;
      rxd_q        <= '0;
      take_q       <= 1'b0;
      busy_q       <= 1'b0;
      poll_frame_q <= 1'b0;
      poll_next_q  <= 1'b0;
      addr_q       <= '0;
      ntx_q        <= '0;
      nall_q       <= '0;
      byte_q       <= '0;
      bit_q        <= '0;
      gap_q        <= '0;
    end else begin
      rxv_q  <= 1'b0;
      take_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q      <= ST_SHIFT;
            cs_n_q       <= 1'b0;
            irq_q        <= 1'b0;
            addr_q       <= req_addr_i;
            ntx_q        <= ntx_d;
            nall_q       <= nall_d;
            byte_q       <= '0;
            bit_q        <= '0;
            poll_frame_q <= 1'b0;
            poll_next_q  <= op_needs_poll(req_op_i);
          end
        end
        ST_SHIFT: begin
          if (sck_rise && rx_phase && byte_end) begin
            if (poll_frame_q) busy_q <= miso_i;  // status bit 0 arrives last
            else begin
              rxv_q <= 1'b1;
              rxd_q <= rx_next;
            end
          end
          if (sck_fall) begin
            if (frame_last) begin
              state_q <= ST_GAP;
              cs_n_q  <= 1'b1;
              gap_q   <= '0;
            end else if (byte_end) begin
              byte_q <= nxt_idx;
              bit_q  <= '0;
              take_q <= nxt_take;
            end else begin
              bit_q <= bit_q + 3'd1;
            end
          end
        end
        ST_GAP: begin
          gap_q <= gap_q + GAP_W'(1);
          if (gap_done) begin
            if (poll_go) begin
              state_q      <= ST_SHIFT;
              cs_n_q       <= 1'b0;
              ntx_q        <= IDX_W'(1);
              nall_q       <= IDX_W'(2);
              byte_q       <= '0;
              bit_q        <= '0;
              poll_frame_q <= 1'b1;
              poll_next_q  <= 1'b0;
            end else begin
              if (poll_frame_q) irq_q <= 1'b1;
              poll_frame_q <= 1'b0;
              state_q      <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_n_o       = cs_n_q;
  assign irq_o        = irq_q;
  assign rx_valid_o   = rxv_q;
  assign rx_data_o    = rxd_q;
  assign wdata_take_o = take_q;

  assert_sck_low_deselected_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o |-> !sck_o);
  assert_cs_gap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_n_o) |=> cs_n_o);
  assert_busy_in_frame_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_n_o |-> !req_ready_o);
  assert_rx_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
  assert_take_in_frame_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdata_take_o |-> !cs_n_o);
  assert_irq_at_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> req_ready_o);
  assert_no_rx_in_poll_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_frame_q |-> !rx_valid_o);
endmodule

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;
  localparam int unsigned H  = 2;
  localparam int unsigned ML = 256;
  localparam int unsigned LW = $clog2(ML + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          req_valid = 1'b0;
  logic [7:0]    req_op = '0;
  logic [23:0]   req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic [7:0]    wbuf [256];
  int            wptr = 0;
  logic [7:0]    wdata;
  logic          req_ready, take, rxv, irq, cs_n, sck, mosi;
  logic          miso = 1'b0;
  logic [7:0]    rxd;

  assign wdata = wbuf[wptr[7:0]];

  flash_cmd_seq #(.SCK_HALF(H), .MAX_LEN(ML)) u_flash_cmd_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_addr_i(req_addr), .req_len_i(req_len), .wdata_i(wdata),
    .wdata_take_o(take), .rx_data_o(rxd), .rx_valid_o(rxv), .irq_o(irq),
    .cs_n_o(cs_n), .sck_o(sck), .mosi_o(mosi), .miso_i(miso));

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] pat(input logic [23:0] a);
    logic [23:0] t;
    t = a * 24'd13 + 24'h3C;
    return t[7:0];
  endfunction

  function automatic bit known(input logic [7:0] op);
    return op == 8'h06 || op == 8'h20 || op == 8'h02 || op == 8'h03 || op == 8'h05;
  endfunction

  // ---------------- behavioural reference model ----------------
  int   m_st = 0, m_t = 0, m_g = 0, m_ntx = 0, m_nall = 0, m_mb = 0;
  bit   m_poll = 0, m_pnext = 0, m_brep = 0;
  logic [7:0]  m_op = '0;
  logic [23:0] m_addr = '0;
  bit   txq [$];
  logic e_cs = 1, e_sck = 0, e_mosi = 0, e_ready = 1, e_irq = 0, e_rxv = 0, e_take = 0, e_mchk = 0;
  logic [7:0] e_rxd = '0;
  int   busy_polls = 0;

  task automatic start_frame(input logic [7:0] op, input logic [23:0] a, input int len, input bit poll);
    txq.delete();
    for (int i = 7; i >= 0; i--) txq.push_back(op[i]);
    if (op == 8'h20 || op == 8'h02 || op == 8'h03)
      for (int i = 23; i >= 0; i--) txq.push_back(a[i]);
    if (op == 8'h02)
      for (int k = 0; k < len; k++) for (int i = 7; i >= 0; i--) txq.push_back(wbuf[k][i]);
    m_ntx  = txq.size();
    m_nall = m_ntx + ((op == 8'h03) ? 8 * len : (op == 8'h05) ? 8 : 0);
    m_op = op; m_addr = a; m_t = 0; m_st = 1; m_poll = poll;
    m_pnext = !poll && (op == 8'h20 || op == 8'h02);
    e_cs = 0; e_sck = 0; e_mosi = txq[0]; e_mchk = 1; e_ready = 0;
  endtask

  always @(posedge clk) begin : mdl
    int m, b, j;
    if (!rst_n) begin
      m_st = 0; e_cs = 1; e_sck = 0; e_ready = 1; e_irq = 0; e_rxv = 0; e_take = 0; e_mchk = 0;
    end else begin
      e_rxv = 0; e_take = 0;
      case (m_st)
        0: if (req_valid && known(req_op)) begin
             e_irq = 0;
             m_mb = busy_polls;
             start_frame(req_op, req_addr, int'(req_len), 0);
           end
        1: begin
          m_t++;
          if (m_t % H == 0) begin
            m = m_t / H;
            if (m % 2 == 1) begin
              b = (m - 1) / 2; e_sck = 1;
              if (b >= m_ntx && (b - m_ntx) % 8 == 7) begin
                j = (b - m_ntx) / 8;
                if (m_poll) m_brep = (m_mb > 0);
                else begin
                  e_rxv = 1;
                  e_rxd = (m_op == 8'h03) ? pat(m_addr + 24'(j)) : 8'hAC;
                end
              end
            end else begin
              b = m / 2; e_sck = 0;
              if (b == m_nall) begin
                e_cs = 1; e_mchk = 0; m_st = 2; m_g = 0;
                if (m_poll && m_mb > 0) m_mb--;
              end else begin
                e_mchk = (b < m_ntx);
                e_mosi = (b < m_ntx) ? txq[b] : 1'b0;
                if (m_op == 8'h02 && b >= 32 && b < m_ntx && (b - 32) % 8 == 0) e_take = 1;
              end
            end
          end
        end
        default: begin
          m_g++;
          if (m_g == 2 * H) begin
            if (m_pnext || (m_poll && m_brep)) start_frame(8'h05, 24'h0, 0, 1);
            else begin
              if (m_poll) e_irq = 1;
              m_poll = 0; m_st = 0; e_ready = 1;
            end
          end
        end
      endcase
    end
  end

  // ---------------- flash model ----------------
  int f_rc = 0, f_fb = 0, f_ntx, f_p;
  logic [7:0] f_op = '0, f_byte;
  logic [23:0] f_addr = '0;
  logic f_psck = 0, f_pcs = 1;

  always @(negedge clk) begin
    if (cs_n) begin
      if (!f_pcs && f_op == 8'h05 && f_rc >= 16 && f_fb > 0) f_fb--;
      f_rc = 0; f_op = '0; f_addr = '0;
    end else if (sck && !f_psck) begin
      if (f_rc < 8) f_op = {f_op[6:0], mosi};
      else if (f_rc < 32) f_addr = {f_addr[22:0], mosi};
      f_rc++;
    end else if (!sck && f_psck) begin
      f_ntx = (f_op == 8'h03) ? 32 : (f_op == 8'h05) ? 8 : 1 << 30;
      if (f_rc >= f_ntx) begin
        f_p = f_rc - f_ntx;
        f_byte = (f_op == 8'h03) ? pat(f_addr + 24'(f_p / 8)) : (8'hAC | 8'(f_fb > 0));
        miso = f_byte[7 - f_p % 8];
      end
    end
    f_psck = sck; f_pcs = cs_n;
  end

  // ---------------- monitors and per-cycle compare ----------------
  int frames = 0, rises = 0;
  logic p_cs = 1, p_sck = 0;
  always @(negedge clk) begin
    if (take) wptr++;
    if (!cs_n && p_cs) frames++;
    if (sck && !p_sck) rises++;
    p_cs = cs_n; p_sck = sck;
    if (rst_n) begin
      chk(cs_n === e_cs, "R6 cs_n", 32'(cs_n), 32'(e_cs));
      chk(sck === e_sck, "R3 sck", 32'(sck), 32'(e_sck));
      chk(req_ready === e_ready, "R7 ready", 32'(req_ready), 32'(e_ready));
      chk(irq === e_irq, "R9 irq", 32'(irq), 32'(e_irq));
      chk(rxv === e_rxv, "R5/R8 rx_valid", 32'(rxv), 32'(e_rxv));
      chk(take === e_take, "R4 take", 32'(take), 32'(e_take));
      if (e_rxv) chk(rxd === e_rxd, "R5 rx_data", 32'(rxd), 32'(e_rxd));
      if (e_mchk && !e_cs) chk(mosi === e_mosi, "R4 mosi", 32'(mosi), 32'(e_mosi));
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic send(input logic [7:0] op, input logic [23:0] a, input int len, input int bp);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    busy_polls = bp; f_fb = bp;
    frames = 0; rises = 0; wptr = 0;
    req_op = op; req_addr = a; req_len = LW'(len); req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    while (!req_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) wbuf[i] = 8'(i * 37 + 5);
    repeat (3) @(negedge clk);
    chk(cs_n === 1'b1 && sck === 1'b0 && irq === 1'b0, "R1 reset outputs", {cs_n, sck, irq}, 3'b100);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready === 1'b1 && cs_n === 1'b1, "R1 ready after reset", {req_ready, cs_n}, 2'b11);

    send(8'h06, 24'h0, 0, 0);
    chk(rises == 8, "R10 wr-enable bit count", rises, 8);
    chk(frames == 1 && irq === 1'b0, "R10 one frame no irq", {frames[7:0], irq}, 9'h002);

    send(8'h05, 24'h0, 0, 0);
    chk(rises == 16, "R5 status read bits", rises, 16);

    send(8'h03, 24'h12345F, 5, 0);
    chk(rises == 72, "R5 read 5 bytes bits", rises, 72);

    send(8'h03, 24'hFFFFFE, 0, 0);
    chk(rises == 32, "R5 zero-length read", rises, 32);

    send(8'h9F, 24'h0, 0, 0);
    chk(frames == 0 && cs_n === 1'b1 && req_ready === 1'b1, "R2 unknown opcode ignored",
        {frames[7:0], cs_n, req_ready}, 10'h003);

    send(8'h20, 24'h00A000, 0, 3);
    chk(frames == 5, "R8 erase plus four polls", frames, 5);
    chk(irq === 1'b1, "R9 irq after erase", irq, 1);

    send(8'h06, 24'h0, 0, 0);
    chk(irq === 1'b0, "R9 irq cleared by accept", irq, 0);

    send(8'h02, 24'h000100, 4, 0);
    chk(frames == 2 && wptr == 4, "R4 program 4 bytes one poll", {frames[7:0], wptr[7:0]}, 16'h0204);

    send(8'h02, 24'h003F00, 256, 1);
    chk(wptr == 256, "R4 full page take count", wptr, 256);
    chk(frames == 3 && irq === 1'b1, "R8 page program polls", {frames[7:0], irq}, 9'h007);

    // requests while busy are ignored
    @(negedge clk);
    frames = 0; busy_polls = 0; f_fb = 0;
    req_op = 8'h03; req_addr = 24'h000010; req_len = LW'(2); req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    repeat (4) @(negedge clk);
    req_op = 8'h06; req_valid = 1;
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b0, "R7 ready low in frame", req_ready, 0);
    req_valid = 0;
    while (!req_ready) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(frames == 1, "R7 busy request dropped", frames, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule